// File: doc/BRIEF.md
# Programmable Reference Divider

The reference divider turns the selected reference clock into the slower pulse train that drives the reference side of a phase-frequency detector. A 14-bit divisor is supplied as two register fields: a low byte and a 6-bit upper part. The divider emits a single-cycle pulse once every R reference cycles.

The counter can be cleared in four ways: the chip-level reset, a clear bit of its own, a clear bit it shares with the feedback counters, and a synchronization event. Any of these forces the output low at once, without waiting for a clock edge. Counting resumes only after the clear has been carried through a synchronizer clocked by the reference, so every clear restarts the pulse phase at a known edge.

A new divisor is sampled only at terminal count. Software can therefore write the two fields in any order while the divider runs, and a period never comes out shortened or stretched.

Top module: `refDivider`

## Requirements
- R1: The divisor R is the 14-bit value {divHi, divLo}: divHi supplies bits 13..8 and divLo supplies bits 7..0. Every value from 0 to 16383 is accepted, including 255, 256 and 16383.
- R2: For R of 2 or more, pfdPulse is high for exactly one refClk cycle in every R cycles and low in all the others.
- R3: R = 0 and R = 1 both divide by one, so pfdPulse is high on every refClk cycle.
- R4: A change of divisor takes effect only at the next terminal count. The period in progress completes with the old value. A value that is written and then replaced before that terminal count has no effect.
- R5: rstN low forces pfdPulse low at once, with no clock edge needed, and holds the counter cleared.
- R6: clrOwn high forces pfdPulse low at once and holds the counter cleared.
- R7: clrShared high forces pfdPulse low at once and holds the counter cleared.
- R8: clrSync high forces pfdPulse low at once and holds the counter cleared.
- R9: Once every clear source is inactive, the first pulse appears after the third rising edge of refClk (synchronizer depth of 2, plus one). Further pulses follow every R cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Selected reference clock |
| rstN | input | 1 | Chip reset, active low |
| clrOwn | input | 1 | Divider's own clear, active high |
| clrShared | input | 1 | Clear shared with the feedback counters, active high |
| clrSync | input | 1 | Synchronization clear, active high |
| divLo | input | 8 | Divisor bits 7..0 |
| divHi | input | 6 | Divisor bits 13..8 |
| pfdPulse | output | 1 | Divided pulse train to the detector |

## Verification
The assertions check the following on every cycle:
- the countdown steps by exactly one whatever the divisor inputs do;
- no pulse is produced away from terminal count;
- a divisor of 0 or 1 keeps the pulse high;
- the output is silent while any clear is held;
- the synchronizer releases only after its first stage has been set.

Only the bench scenarios can show the following:
- the end-to-end period for each divisor;
- the exact edge of the first pulse after a release;
- the immediate, clockless clearing of the output;
- a mid-period divisor rewrite that leaves the current period intact.

// File: rtl/refDivPkg.sv
package refDivPkg;
  // Control-to-datapath strobes, one cycle wide
  typedef struct packed {
    logic reload;  // terminal count reached: load new period
    logic step;    // mid-period: count down
  } divStrobe_t;
endpackage

// File: rtl/refDivCtl.sv
module refDivCtl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  refClk,
  input  logic                  rstN,
  input  logic                  clrOwn,
  input  logic                  clrShared,
  input  logic                  clrSync,
  input  logic                  atTerm,
  output logic                  runN,
  output refDivPkg::divStrobe_t strobe
);
  logic clrAllN;
  logic [SYNC_STAGES-1:0] syncChain;

  // Any source clears; assertion is asynchronous
  assign clrAllN = rstN & ~(clrOwn | clrShared | clrSync);

  // Release is synchronous: ones shift in from the low end
  always_ff @(posedge refClk or negedge clrAllN) begin
    if (!clrAllN) syncChain <= '0;
    else          syncChain <= {syncChain[SYNC_STAGES-2:0], 1'b1};
  end

  assign runN = syncChain[SYNC_STAGES-1];

  always_comb begin
    strobe.reload = runN & atTerm;
    strobe.step   = runN & ~atTerm;
  end

  // R9: the run enable rises only after the stage before it was set
  a_r9_release_order: assert property (@(posedge refClk) disable iff (!clrAllN)
    $rose(runN) |-> $past(syncChain[SYNC_STAGES-2]));
endmodule

// File: rtl/refDivPath.sv
module refDivPath #(
  parameter int CNT_W = 14
) (
  input  logic                  refClk,
  input  logic                  runN,
  input  logic [7:0]            divLo,
  input  logic [CNT_W-9:0]      divHi,
  input  refDivPkg::divStrobe_t strobe,
  output logic                  atTerm,
  output logic                  pfdPulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] divReq;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cnt;

  assign divReq    = {divHi, divLo};
  // 0 and 1 both mean divide-by-one: reload zero, stay at terminal
  assign reloadVal = (divReq <= ONE) ? '0 : divReq - ONE;

  always_ff @(posedge refClk or negedge runN) begin
    if (!runN) begin
      cnt      <= '0;
      pfdPulse <= 1'b0;
    end else begin
      if (strobe.reload)    cnt <= reloadVal;
      else if (strobe.step) cnt <= cnt - ONE;
      pfdPulse <= strobe.reload;
    end
  end

  assign atTerm = (cnt == '0);

  // R2: no pulse is issued away from terminal count
  a_r2_one_high: assert property (@(posedge refClk) disable iff (!runN)
    (cnt != '0) |=> !pfdPulse);

  // R4: mid-period counting ignores the divisor inputs
  a_r4_steady_count: assert property (@(posedge refClk) disable iff (!runN)
    (cnt != '0) |=> (cnt == $past(cnt) - ONE));

  // R3: divide-by-one keeps firing
  a_r3_unity: assert property (@(posedge refClk) disable iff (!runN)
    (atTerm && divReq <= ONE) |=> (pfdPulse && atTerm));
endmodule

// File: rtl/refDivider.sv
module refDivider #(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             clrOwn,
  input  logic             clrShared,
  input  logic             clrSync,
  input  logic [7:0]       divLo,
  input  logic [CNT_W-9:0] divHi,
  output logic             pfdPulse
);
  logic runN;
  logic atTerm;
  refDivPkg::divStrobe_t strobe;

  refDivCtl #(.SYNC_STAGES(SYNC_STAGES)) ctl (
    .refClk(refClk), .rstN(rstN), .clrOwn(clrOwn), .clrShared(clrShared),
    .clrSync(clrSync), .atTerm(atTerm), .runN(runN), .strobe(strobe)
  );

  refDivPath #(.CNT_W(CNT_W)) path (
    .refClk(refClk), .runN(runN), .divLo(divLo), .divHi(divHi),
    .strobe(strobe), .atTerm(atTerm), .pfdPulse(pfdPulse)
  );

  // R6, R7, R8: a held clear keeps the output silent
  a_r6_clear_quiet: assert property (@(posedge refClk) disable iff (!rstN)
    (clrOwn | clrShared | clrSync) |-> !pfdPulse);
endmodule

// File: tb/refDivider_test.sv
module refDivider_test;
  localparam int PERIOD = 10;
  localparam int LAT    = 3;

  logic refClk = 1'b0;
  logic rstN = 1'b0, clrOwn = 1'b0, clrShared = 1'b0, clrSync = 1'b0;
  logic [7:0] divLo = '0;
  logic [5:0] divHi = '0;
  logic pfdPulse;
  int checks = 0;
  int errors = 0;
  string clrTag [4] = '{"R5", "R6", "R7", "R8"};

  always #(PERIOD/2) refClk = ~refClk;

  refDivider uut (
    .refClk(refClk), .rstN(rstN), .clrOwn(clrOwn), .clrShared(clrShared),
    .clrSync(clrSync), .divLo(divLo), .divHi(divHi), .pfdPulse(pfdPulse)
  );

  task automatic check(logic got, logic exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pfdPulse=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic setDiv(int r);
    {divHi, divLo} = r[13:0];
  endtask

  task automatic drive(int sel, logic v);
    case (sel)
      0: rstN = ~v;
      1: clrOwn = v;
      2: clrShared = v;
      default: clrSync = v;
    endcase
  endtask

  // Pulse a clear for one cycle; returns at the release negedge
  task automatic restart(int sel);
    @(negedge refClk); drive(sel, 1'b1);
    @(negedge refClk); check(pfdPulse, 1'b0, clrTag[sel]); drive(sel, 1'b0);
  endtask

  task automatic runDiv(int r, int periods, int sel, string req);
    int eff = (r <= 1) ? 1 : r;
    @(negedge refClk); setDiv(r);
    restart(sel);
    for (int k = 1; k <= LAT - 1 + periods * eff; k++) begin
      @(negedge refClk);
      check(pfdPulse, (k >= LAT) && ((k - LAT) % eff == 0), req);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    setDiv(4);
    repeat (3) @(negedge refClk);
    check(pfdPulse, 1'b0, "R5");
    rstN = 1'b1;

    // R2 / R3 / R9 sweep, rotating through all clear sources
    for (int r = 0; r <= 20; r++)
      runDiv(r, 3, r % 4, (r <= 1) ? "R3/R9" : "R2/R9");

    // R1: byte boundary and full-scale divisors
    runDiv(255, 2, 1, "R1");
    runDiv(256, 2, 2, "R1");
    runDiv(16383, 1, 3, "R1");

    // R4: rewrites mid-period apply only at terminal count
    @(negedge refClk); setDiv(5);
    restart(1);
    for (int k = 1; k <= 30; k++) begin
      @(negedge refClk);
      check(pfdPulse, (k == 3) || (k == 8) || (k == 17) || (k == 26), "R4");
      if (k == 3)  setDiv(9);
      if (k == 10) setDiv(2);
      if (k == 12) setDiv(9);
    end

    // R5..R8: each clear kills a high output without a clock edge
    for (int sel = 0; sel < 4; sel++) begin
      @(negedge refClk); setDiv(1);
      restart(sel);
      repeat (LAT) @(negedge refClk);
      check(pfdPulse, 1'b1, "R3");
      drive(sel, 1'b1);
      #1;
      check(pfdPulse, 1'b0, clrTag[sel]);
      @(negedge refClk);
      check(pfdPulse, 1'b0, clrTag[sel]);
      drive(sel, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule